// File: doc/BRIEF.md
# Paged Memory Address Mapper

The mapper sits between a 16-bit processor address bus and a small set of physical memory regions. The address space is cut into equal pages. For each page it keeps two independent entries, one used by reads and one used by writes. Each entry is either empty or names a region index and a physical page number. A page can therefore be readable, writable, both or neither, and its read and write sides can point at different storage. An access is translated in the cycle it is presented. The physical address is the entry's page number followed by the in-page bits of the processor address.

Software changes the mapping through a configuration port. One request covers a contiguous run of pages, which is given as a page-aligned start address and a byte size. The request can map or unmap the read side, the write side or both. Consecutive pages in the run receive consecutive physical page numbers. Pages without a read entry return an all-ones filler byte, and writes to pages without a write entry are dropped. A mapped entry may also select a wait map. A wait map is a short table of stall counts, indexed by a free-running cycle counter modulo the table length. It stretches the access by the value it holds.

Top module: `paged_mapper`

## Requirements
- R1: After reset every page is unmapped on both sides. Any access completes in its first cycle (`cpu_ready_o` high), `mem_en_o` stays low, and `cfg_err_o` is 0.
- R2: A map request covering both sides (`cfg_op_i`=3) sets page `s+k` of the run to region `cfg_region_i` and physical page `(cfg_pbase_i+k) mod 2^POFS_W`. An access then drives `mem_region_o` to that region and `mem_addr_o` to `{physical page, cpu_addr_i[PAGE_BITS-1:0]}`, with `mem_en_o` high in its completing cycle. `mem_we_o` equals `cpu_we_i`, and write data is passed through unchanged.
- R3: A read-side map (`cfg_op_i`=1) changes only the read entries. A write-side map (`cfg_op_i`=2) changes only the write entries.
- R4: A read from a page with no read entry returns 0xFF on `cpu_rdata_o` and does not raise `mem_en_o`.
- R5: A write to a page with no write entry never raises `mem_en_o` or `mem_we_o`.
- R6: A size of zero in `cfg_size_i` covers all pages of the address space.
- R7: A request is rejected when it is misaligned (a nonzero value in `cfg_addr_i[PAGE_BITS-1:0]` or in `cfg_size_i[PAGE_BITS-1:0]`) or when it runs past the last page. A rejected request sets `cfg_err_o` to 1 from the next cycle and leaves both tables unchanged. Any accepted request clears `cfg_err_o`.
- R8: `cfg_op_i`=0 writes `cfg_wval_i` into entry `cfg_addr_i[1:0]` of wait map `cfg_wsel_i`. A mapped access whose entry has `cfg_wen_i` set samples value W from its wait map, at the index given by the count of clock edges since reset modulo 4, in its first cycle. `cpu_ready_o` then rises W cycles later. `mem_en_o` is held low until then.
- R9: An access to a page without an entry on its side completes in its first cycle, whatever wait setting the page held before.
- R10: A table change is seen by the access presented in the cycle right after the configuration cycle.
- R11: Unmap requests (`cfg_op_i`=5 read side, 6 write side, 7 both) clear the entries of the covered pages. `cfg_op_i`=4 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configuration request strobe |
| cfg_op_i | input | 3 | Request code: 0 wait load, 1/2/3 map rd/wr/both, 4 none, 5/6/7 unmap rd/wr/both |
| cfg_addr_i | input | ADDR_W | Run start address, or wait-map entry index |
| cfg_size_i | input | ADDR_W | Run size in bytes, 0 means whole space |
| cfg_region_i | input | REGION_W | Region index for mapped pages |
| cfg_pbase_i | input | POFS_W | Physical page of the first page in the run |
| cfg_wen_i | input | 1 | Mapped pages use a wait map |
| cfg_wsel_i | input | WSEL_W | Wait map selector |
| cfg_wval_i | input | WAIT_W | Stall count for a wait-map load |
| cfg_err_o | output | 1 | Last request was rejected |
| cpu_req_i | input | 1 | Access request, held until ready |
| cpu_we_i | input | 1 | Access is a write |
| cpu_addr_i | input | ADDR_W | Processor address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data or filler |
| cpu_ready_o | output | 1 | Access completes this cycle |
| mem_en_o | output | 1 | Physical access strobe |
| mem_we_o | output | 1 | Physical write |
| mem_region_o | output | REGION_W | Target region |
| mem_addr_o | output | POFS_W+PAGE_BITS | Physical address within region |
| mem_wdata_o | output | DATA_W | Write data to memory |
| mem_rdata_i | input | DATA_W | Read data from selected region |

## Verification
The properties assume that the processor side keeps a request, its address and its direction steady until `cpu_ready_o` rises. They also assume that `mem_rdata_i` responds combinationally to the physical address. The bench drives each access through one task that holds all access inputs unchanged through every stall cycle and drops the request only after the completing cycle. It models each region as an arithmetic function of region and address, so read data needs no storage. Configuration requests go out one at a time and never overlap an access, so no table change can land in the middle of a stall.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  typedef enum logic [2:0] {
    OP_WLOAD    = 3'd0,
    OP_MAP_RD   = 3'd1,
    OP_MAP_WR   = 3'd2,
    OP_MAP_RW   = 3'd3,
    OP_NONE     = 3'd4,
    OP_UNMAP_RD = 3'd5,
    OP_UNMAP_WR = 3'd6,
    OP_UNMAP_RW = 3'd7
  } cfg_op_e;

  // direction index into per-side arrays
  localparam int unsigned SIDE_RD = 0;
  localparam int unsigned SIDE_WR = 1;
endpackage

// File: rtl/pmap_cfg_decode.sv
module pmap_cfg_decode
  import pmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned PIDX_W   = ADDR_W - PAGE_BITS,
  localparam int unsigned NPAGES   = 1 << PIDX_W
) (
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] size_i,
  output logic              upd_rd_o,
  output logic              upd_wr_o,
  output logic              set_o,
  output logic              wload_o,
  output logic              err_o,
  output logic [PIDX_W-1:0] first_o,
  output logic [PIDX_W:0]   count_o
);
  logic            map_op;
  logic            aligned;
  logic            fits;
  logic [PIDX_W:0] end_pg;

  assign first_o = addr_i[ADDR_W-1:PAGE_BITS];
  // zero size selects the whole space
  assign count_o = (size_i[ADDR_W-1:PAGE_BITS] == '0) ? (PIDX_W+1)'(NPAGES)
                                                       : {1'b0, size_i[ADDR_W-1:PAGE_BITS]};
  assign end_pg  = {1'b0, first_o} + count_o;
  assign aligned = (addr_i[PAGE_BITS-1:0] == '0) && (size_i[PAGE_BITS-1:0] == '0);
  assign fits    = end_pg <= (PIDX_W+1)'(NPAGES);
  assign map_op  = op_i[1:0] != 2'b00;

  assign err_o    = valid_i && map_op && !(aligned && fits);
  assign upd_rd_o = valid_i && map_op && aligned && fits && op_i[0];
  assign upd_wr_o = valid_i && map_op && aligned && fits && op_i[1];
  assign set_o    = !op_i[2];
  assign wload_o  = valid_i && (op_i == OP_WLOAD);
endmodule

// File: rtl/pmap_page_table.sv
module pmap_page_table #(
  parameter int unsigned PIDX_W   = 4,
  parameter int unsigned REGION_W = 2,
  parameter int unsigned POFS_W   = 4,
  parameter int unsigned WSEL_W   = 1,
  localparam int unsigned NPAGES  = 1 << PIDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic                set_i,
  input  logic [PIDX_W-1:0]   first_i,
  input  logic [PIDX_W:0]     count_i,
  input  logic [REGION_W-1:0] region_i,
  input  logic [POFS_W-1:0]   pbase_i,
  input  logic                wen_i,
  input  logic [WSEL_W-1:0]   wsel_i,
  input  logic [PIDX_W-1:0]   lk_page_i,
  output logic                hit_o,
  output logic [REGION_W-1:0] region_o,
  output logic [POFS_W-1:0]   pofs_o,
  output logic                wen_o,
  output logic [WSEL_W-1:0]   wsel_o
);
  logic [NPAGES-1:0] vld_all;
  logic [NPAGES-1:0] wen_all;
  logic [REGION_W-1:0] reg_all  [NPAGES];
  logic [POFS_W-1:0]   pofs_all [NPAGES];
  logic [WSEL_W-1:0]   wsel_all [NPAGES];

  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    localparam logic [PIDX_W:0] PV = (PIDX_W+1)'(p);
    logic                rel_ok;
    logic [PIDX_W:0]     rel;
    logic                vld_q, wen_q;
    logic [REGION_W-1:0] reg_q;
    logic [POFS_W-1:0]   pofs_q;
    logic [WSEL_W-1:0]   wsel_q;

    assign rel    = PV - {1'b0, first_i};
    assign rel_ok = (PV >= {1'b0, first_i}) && (rel < count_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        wen_q  <= 1'b0;
        reg_q  <= '0;
        pofs_q <= '0;
        wsel_q <= '0;
      end else if (upd_i && rel_ok) begin
        vld_q  <= set_i;
        wen_q  <= set_i && wen_i;
        reg_q  <= region_i;
        pofs_q <= pbase_i + POFS_W'(rel);
        wsel_q <= wsel_i;
      end
    end

    assign vld_all[p]  = vld_q;
    assign wen_all[p]  = wen_q;
    assign reg_all[p]  = reg_q;
    assign pofs_all[p] = pofs_q;
    assign wsel_all[p] = wsel_q;
  end

  assign hit_o    = vld_all[lk_page_i];
  assign wen_o    = wen_all[lk_page_i];
  assign region_o = reg_all[lk_page_i];
  assign pofs_o   = pofs_all[lk_page_i];
  assign wsel_o   = wsel_all[lk_page_i];
endmodule

// File: rtl/pmap_wait.sv
module pmap_wait #(
  parameter int unsigned WSEL_W   = 1,
  parameter int unsigned WMAP_LEN = 4,
  parameter int unsigned WAIT_W   = 2,
  localparam int unsigned WIDX_W  = $clog2(WMAP_LEN),
  localparam int unsigned NUM_WMAP = 1 << WSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wload_i,
  input  logic [WSEL_W-1:0] wl_sel_i,
  input  logic [WIDX_W-1:0] wl_idx_i,
  input  logic [WAIT_W-1:0] wl_val_i,
  input  logic              req_i,
  input  logic              wen_i,
  input  logic [WSEL_W-1:0] wsel_i,
  output logic              ready_o
);
  logic [WAIT_W-1:0] wmap_q [NUM_WMAP][WMAP_LEN];
  logic [WIDX_W-1:0] cyc_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              busy_q;
  logic [WAIT_W-1:0] wcur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int m = 0; m < NUM_WMAP; m++)
        for (int e = 0; e < WMAP_LEN; e++) wmap_q[m][e] <= '0;
    end else if (wload_i) begin
      wmap_q[wl_sel_i][wl_idx_i] <= wl_val_i;
    end
  end

  // free-running cycle count modulo the wait-map length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q == WIDX_W'(WMAP_LEN - 1)) cyc_q <= '0;
    else cyc_q <= cyc_q + 1'b1;
  end

  assign wcur    = wen_i ? wmap_q[wsel_i][cyc_q] : '0;
  assign ready_o = req_i && (busy_q ? (cnt_q == WAIT_W'(1)) : (wcur == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (req_i && wcur != '0) begin
        busy_q <= 1'b1;
        cnt_q  <= wcur;
      end
    end else if (cnt_q == WAIT_W'(1)) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/paged_mapper.sv
module paged_mapper
  import pmap_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned REGION_W  = 2,
  parameter int unsigned POFS_W    = 4,
  parameter int unsigned WSEL_W    = 1,
  parameter int unsigned WMAP_LEN  = 4,
  parameter int unsigned WAIT_W    = 2,
  parameter logic [DATA_W-1:0] FILL = '1,
  localparam int unsigned PIDX_W   = ADDR_W - PAGE_BITS,
  localparam int unsigned PHYS_W   = POFS_W + PAGE_BITS,
  localparam int unsigned WIDX_W   = $clog2(WMAP_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_valid_i,
  input  logic [2:0]          cfg_op_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [ADDR_W-1:0]   cfg_size_i,
  input  logic [REGION_W-1:0] cfg_region_i,
  input  logic [POFS_W-1:0]   cfg_pbase_i,
  input  logic                cfg_wen_i,
  input  logic [WSEL_W-1:0]   cfg_wsel_i,
  input  logic [WAIT_W-1:0]   cfg_wval_i,
  output logic                cfg_err_o,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic [DATA_W-1:0]   cpu_wdata_i,
  output logic [DATA_W-1:0]   cpu_rdata_o,
  output logic                cpu_ready_o,
  output logic                mem_en_o,
  output logic                mem_we_o,
  output logic [REGION_W-1:0] mem_region_o,
  output logic [PHYS_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  logic              upd [2];
  logic              set_pg, wload, dec_err, err_q;
  logic [PIDX_W-1:0] first_pg;
  logic [PIDX_W:0]   count_pg;

  logic                hit_d  [2];
  logic [REGION_W-1:0] reg_d  [2];
  logic [POFS_W-1:0]   pofs_d [2];
  logic                wen_d  [2];
  logic [WSEL_W-1:0]   wsel_d [2];

  logic sel_hit;
  logic ready;

  pmap_cfg_decode #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_dec (
    .valid_i (cfg_valid_i),
    .op_i    (cfg_op_i),
    .addr_i  (cfg_addr_i),
    .size_i  (cfg_size_i),
    .upd_rd_o(upd[SIDE_RD]),
    .upd_wr_o(upd[SIDE_WR]),
    .set_o   (set_pg),
    .wload_o (wload),
    .err_o   (dec_err),
    .first_o (first_pg),
    .count_o (count_pg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (cfg_valid_i) err_q <= dec_err;
  end
  assign cfg_err_o = err_q;

  // one table per access direction
  for (genvar s = 0; s < 2; s++) begin : g_side
    pmap_page_table #(
      .PIDX_W(PIDX_W), .REGION_W(REGION_W), .POFS_W(POFS_W), .WSEL_W(WSEL_W)
    ) u_tbl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (upd[s]),
      .set_i    (set_pg),
      .first_i  (first_pg),
      .count_i  (count_pg),
      .region_i (cfg_region_i),
      .pbase_i  (cfg_pbase_i),
      .wen_i    (cfg_wen_i),
      .wsel_i   (cfg_wsel_i),
      .lk_page_i(cpu_addr_i[ADDR_W-1:PAGE_BITS]),
      .hit_o    (hit_d[s]),
      .region_o (reg_d[s]),
      .pofs_o   (pofs_d[s]),
      .wen_o    (wen_d[s]),
      .wsel_o   (wsel_d[s])
    );
  end

  assign sel_hit = hit_d[cpu_we_i];

  pmap_wait #(.WSEL_W(WSEL_W), .WMAP_LEN(WMAP_LEN), .WAIT_W(WAIT_W)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wload_i (wload),
    .wl_sel_i(cfg_wsel_i),
    .wl_idx_i(cfg_addr_i[WIDX_W-1:0]),
    .wl_val_i(cfg_wval_i),
    .req_i   (cpu_req_i),
    .wen_i   (sel_hit && wen_d[cpu_we_i]),
    .wsel_i  (wsel_d[cpu_we_i]),
    .ready_o (ready)
  );

  assign cpu_ready_o  = ready;
  assign mem_en_o     = ready && sel_hit;
  assign mem_we_o     = ready && sel_hit && cpu_we_i;
  assign mem_region_o = reg_d[cpu_we_i];
  assign mem_addr_o   = {pofs_d[cpu_we_i], cpu_addr_i[PAGE_BITS-1:0]};
  assign mem_wdata_o  = cpu_wdata_i;
  assign cpu_rdata_o  = hit_d[SIDE_RD] ? mem_rdata_i : FILL;
endmodule

// File: rtl/paged_mapper_chk.sv
module paged_mapper_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PHYS_W    = 16,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_valid_i,
  input logic              cfg_err_o,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              cpu_ready_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [PHYS_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              sel_hit
);
  a_r4_unmapped_read_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && !cpu_we_i && !mem_en_o |-> cpu_rdata_o == FILL);

  a_r5_write_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o && cpu_req_i && cpu_we_i);

  a_r2_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> mem_addr_o[PAGE_BITS-1:0] == cpu_addr_i[PAGE_BITS-1:0] && mem_wdata_o == cpu_wdata_i);

  a_r9_unmapped_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !sel_hit |-> cpu_ready_o);

  a_r8_ready_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);

  // input assumption: a stalled request is held
  a_r8_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_ready_o |=> cpu_req_i && $stable(cpu_addr_i) && $stable(cpu_we_i));

  a_r7_err_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> $stable(cfg_err_o));
endmodule

bind paged_mapper paged_mapper_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PHYS_W(PHYS_W), .FILL(FILL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_valid_i(cfg_valid_i),
  .cfg_err_o  (cfg_err_o),
  .cpu_req_i  (cpu_req_i),
  .cpu_we_i   (cpu_we_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_wdata_i(cpu_wdata_i),
  .cpu_rdata_o(cpu_rdata_o),
  .cpu_ready_o(cpu_ready_o),
  .mem_en_o   (mem_en_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .sel_hit    (sel_hit)
);

// File: tb/tb_paged_mapper.sv
`timescale 1ns/1ps
module tb_paged_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [2:0]  cfg_op = '0;
  logic [15:0] cfg_addr = '0, cfg_size = '0;
  logic [1:0]  cfg_region = '0;
  logic [3:0]  cfg_pbase = '0;
  logic        cfg_wen = 1'b0;
  logic        cfg_wsel = 1'b0;
  logic [1:0]  cfg_wval = '0;
  logic        cfg_err;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready, mem_en, mem_we;
  logic [1:0]  mem_region;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0;
  int bench_cyc;

  // model tables: index 0 read side, 1 write side
  bit       m_v   [2][16];
  bit       m_wen [2][16];
  bit       m_ws  [2][16];
  bit [1:0] m_rg  [2][16];
  bit [3:0] m_po  [2][16];
  bit [1:0] m_wm  [2][4];

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [1:0] rg, input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ {rg, 6'h15};
  endfunction
  assign mem_rdata = mem_fn(mem_region, mem_addr);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bench_cyc <= 0;
    else bench_cyc <= bench_cyc + 1;

  paged_mapper dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_op_i(cfg_op), .cfg_addr_i(cfg_addr), .cfg_size_i(cfg_size),
    .cfg_region_i(cfg_region), .cfg_pbase_i(cfg_pbase), .cfg_wen_i(cfg_wen),
    .cfg_wsel_i(cfg_wsel), .cfg_wval_i(cfg_wval), .cfg_err_o(cfg_err),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_region_o(mem_region), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [2:0] op, input logic [15:0] a, input logic [15:0] s,
                        input logic [1:0] rg, input logic [3:0] pb, input bit wn, input bit ws,
                        input logic [1:0] wv, input string rq);
    int  n, first;
    bit  map_op, ok, exp_err;
    n      = (s[15:12] == 0) ? 16 : int'(s[15:12]);
    first  = int'(a[15:12]);
    map_op = op[1:0] != 2'b00;
    ok     = (a[11:0] == 0) && (s[11:0] == 0) && (first + n <= 16);
    exp_err = map_op && !ok;
    cfg_valid = 1'b1; cfg_op = op; cfg_addr = a; cfg_size = s; cfg_region = rg;
    cfg_pbase = pb; cfg_wen = wn; cfg_wsel = ws; cfg_wval = wv;
    @(posedge clk); @(negedge clk);
    cfg_valid = 1'b0;
    #1 chk(rq, "cfg_err", cfg_err, exp_err);
    if (op == 3'd0) m_wm[ws][a[1:0]] = wv;
    else if (map_op && ok) begin
      for (int p = first; p < first + n; p++)
        for (int sd = 0; sd < 2; sd++)
          if (op[sd]) begin
            m_v[sd][p]   = !op[2];
            m_wen[sd][p] = !op[2] && wn;
            m_ws[sd][p]  = ws;
            m_rg[sd][p]  = rg;
            m_po[sd][p]  = pb + 4'(p - first);
          end
    end
  endtask

  task automatic do_acc(input bit we, input logic [15:0] a, input logic [7:0] wd, input string rq);
    int pg, w, sd;
    bit hit;
    logic [15:0] pa;
    pg = int'(a[15:12]);
    sd = we ? 1 : 0;
    hit = m_v[sd][pg];
    pa = {m_po[sd][pg], a[11:0]};
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    w = (hit && m_wen[sd][pg]) ? int'(m_wm[m_ws[sd][pg]][bench_cyc % 4]) : 0;
    for (int k = 0; k <= w; k++) begin
      if (k < w) begin
        chk(rq, "ready during stall", cpu_ready, 0);
        chk(rq, "mem_en during stall", mem_en, 0);
        @(posedge clk); @(negedge clk); #1;
      end else begin
        chk(rq, "ready", cpu_ready, 1);
        chk(rq, "mem_en", mem_en, hit);
        chk(rq, "mem_we", mem_we, hit && we);
        if (hit) begin
          chk(rq, "mem_region", mem_region, m_rg[sd][pg]);
          chk(rq, "mem_addr", mem_addr, pa);
          if (we) chk(rq, "mem_wdata", mem_wdata, wd);
        end
        if (!we) chk(rq, "cpu_rdata", cpu_rdata, hit ? mem_fn(m_rg[0][pg], pa) : 8'hFF);
      end
    end
    @(posedge clk); @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic sweep(input string rq);
    logic [11:0] offs [3] = '{12'h000, 12'h5A3, 12'hFFF};
    for (int p = 0; p < 16; p++)
      for (int o = 0; o < 3; o++) begin
        do_acc(1'b0, {4'(p), offs[o]}, 8'h00, rq);
        do_acc(1'b1, {4'(p), offs[o]}, 8'(p * 17 + o), rq);
      end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    #9;
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "cfg_err after reset", cfg_err, 0);
    chk("R1", "ready idle", cpu_ready, 0);
    chk("R1", "mem_en idle", mem_en, 0);
    @(negedge clk);
    sweep("R1_R4_R5");

    // R2 both sides
    do_cfg(3'd3, 16'h2000, 16'h4000, 2'd1, 4'd9, 1'b0, 1'b0, 2'd0, "R2");
    sweep("R2");
    // R3 read-only run with physical page wrap, then write-only
    do_cfg(3'd1, 16'h0000, 16'h3000, 2'd2, 4'd14, 1'b0, 1'b0, 2'd0, "R3");
    do_cfg(3'd2, 16'hC000, 16'h4000, 2'd3, 4'd0, 1'b0, 1'b0, 2'd0, "R3");
    sweep("R3");

    // R7 rejected requests, then an accepted one clears the flag
    do_cfg(3'd3, 16'h1001, 16'h1000, 2'd0, 4'd1, 1'b0, 1'b0, 2'd0, "R7");
    do_cfg(3'd3, 16'h1000, 16'h0800, 2'd0, 4'd1, 1'b0, 1'b0, 2'd0, "R7");
    do_cfg(3'd1, 16'hF000, 16'h2000, 2'd0, 4'd1, 1'b0, 1'b0, 2'd0, "R7");
    do_cfg(3'd2, 16'h8000, 16'h9000, 2'd0, 4'd1, 1'b0, 1'b0, 2'd0, "R7");
    sweep("R7");
    do_cfg(3'd4, 16'h0000, 16'h0000, 2'd3, 4'd3, 1'b0, 1'b0, 2'd0, "R11");
    sweep("R11");

    // R6 zero size covers every page
    do_cfg(3'd2, 16'h0000, 16'h0000, 2'd0, 4'd7, 1'b0, 1'b0, 2'd0, "R6");
    sweep("R6");

    // R8 wait maps
    do_cfg(3'd0, 16'h0000, 16'h0, 2'd0, 4'd0, 1'b0, 1'b0, 2'd0, "R8");
    do_cfg(3'd0, 16'h0001, 16'h0, 2'd0, 4'd0, 1'b0, 1'b0, 2'd1, "R8");
    do_cfg(3'd0, 16'h0002, 16'h0, 2'd0, 4'd0, 1'b0, 1'b0, 2'd2, "R8");
    do_cfg(3'd0, 16'h0003, 16'h0, 2'd0, 4'd0, 1'b0, 1'b0, 2'd3, "R8");
    do_cfg(3'd0, 16'h0000, 16'h0, 2'd0, 4'd0, 1'b0, 1'b1, 2'd3, "R8");
    do_cfg(3'd0, 16'h0001, 16'h0, 2'd0, 4'd0, 1'b0, 1'b1, 2'd2, "R8");
    do_cfg(3'd0, 16'h0002, 16'h0, 2'd0, 4'd0, 1'b0, 1'b1, 2'd1, "R8");
    do_cfg(3'd0, 16'h0003, 16'h0, 2'd0, 4'd0, 1'b0, 1'b1, 2'd2, "R8");
    do_cfg(3'd3, 16'h4000, 16'h2000, 2'd2, 4'd4, 1'b1, 1'b0, 2'd0, "R8");
    do_cfg(3'd3, 16'h8000, 16'h1000, 2'd1, 4'd12, 1'b1, 1'b1, 2'd0, "R8");
    sweep("R8");

    // R9 R11 unmapping clears entries and their waits
    do_cfg(3'd5, 16'h0000, 16'h8000, 2'd0, 4'd0, 1'b0, 1'b0, 2'd0, "R11");
    do_cfg(3'd6, 16'h4000, 16'h1000, 2'd0, 4'd0, 1'b0, 1'b0, 2'd0, "R11");
    do_cfg(3'd7, 16'h8000, 16'h1000, 2'd0, 4'd0, 1'b0, 1'b0, 2'd0, "R9");
    sweep("R9_R11");

    // R10 access right after the configuration cycle
    do_cfg(3'd1, 16'hF000, 16'h1000, 2'd2, 4'd1, 1'b0, 1'b0, 2'd0, "R10");
    do_acc(1'b0, 16'hF123, 8'h00, "R10");
    do_cfg(3'd5, 16'hF000, 16'h1000, 2'd0, 4'd0, 1'b0, 1'b0, 2'd0, "R10");
    do_acc(1'b0, 16'hF123, 8'h00, "R10");

    summary();
    $finish;
  end
endmodule